// File: doc/BRIEF.md
# Fractional-N PLL Output Frequency Evaluator

This block works out the output frequency a fractional-N PLL would produce for a given set of configuration fields and a reference oscillator frequency. Register logic pulses `start` whenever any configuration field is written. The block then computes the frequency and reports it on `freq_hz`, with `done` high for one cycle when the value is ready. It models no clock generation and no lock time. It only evaluates the arithmetic the configuration implies.

The multiplier has an integer part and a fractional part of `FRAC_W` bits. An optional prescaler doubles both parts. The reference frequency is multiplied by the combined multiplier word into a 64-bit product. A restoring divider divides that product by the post-divider at one quotient bit per cycle, and the fraction bits are then dropped.

Two conditions skip the divide and give zero one cycle after `start`:
- the PLL is not locked (either the power-down bit or the analog-reset bit is set);
- the post-divider is zero.

A typical reference is 19,200,000 Hz.

Top module: `pll_freq_eval`

## Requirements
- R1: After reset `freq_hz` is 0 and `done` is low.
- R2: If `pwr_down` or `ana_rst` is 1 when `start` is sampled, then in the next cycle `done` is 1 and `freq_hz` is 0. No division is started.
- R3: If `post_div` is 0 when `start` is sampled (and the PLL is locked), then in the next cycle `done` is 1 and `freq_hz` is 0. No division is started.
- R4: Otherwise the result is `(ref_hz * ((int_mul << 20) + frac_mul) / post_div) >> 20`, with FRAC_W = 20, a 10-bit `int_mul` and a 3-bit `post_div`.
- R5: When `pre_dbl` is 1, both `int_mul` and `frac_mul` are doubled before the multiply.
- R6: A divided result appears with `done` high exactly 65 cycles after the clock edge that samples `start`. `done` stays high for one cycle and is low while the divide runs.
- R7: A `start` during a running divide discards that divide. Only one `done` follows, and it carries the result for the field values present at the latest `start`, whether that result is divided or forced to zero.
- R8: `freq_hz` keeps its previous value between results. It changes only in a cycle where `done` is high.
- R9: The quotient is truncated (floor) both in the divide and in the final right shift by 20 bits.
- R10: The widest inputs (all-ones reference, integer and fraction fields, prescaler on, `post_div` of 1) give an exact result with no overflow in the 64-bit product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse when any configuration field is written |
| ref_hz | input | 32 | Reference oscillator frequency in Hz |
| pwr_down | input | 1 | PLL power-down bit |
| ana_rst | input | 1 | PLL analog-reset bit |
| int_mul | input | 10 | Integer part of the multiplier |
| frac_mul | input | 20 | Fractional part of the multiplier |
| post_div | input | 3 | Post-divider, 0 means no output |
| pre_dbl | input | 1 | Prescaler enable, doubles the multiplier |
| freq_hz | output | 44 | Computed output frequency in Hz |
| done | output | 1 | One-cycle pulse when `freq_hz` is fresh |

## Verification
A wrong internal state shows up in three ways:
- A corrupted quotient bit or remainder gives a wrong `freq_hz` at the next `done`. That is at most 65 cycles after the `start` that caused it.
- A miscounted iteration moves `done` off its fixed cycle, so every divided result also gives a timing check.
- A divider left running after a restart or a forced-zero path produces an extra `done`. The scoreboard flags any `done` it has no entry for, along with any expected `done` that never arrives.

// File: rtl/pll_eval_pkg.sv
`timescale 1ns/1ps
package pll_eval_pkg;

  typedef enum logic [1:0] {
    PATH_DIVIDE   = 2'd0,
    PATH_UNLOCKED = 2'd1,
    PATH_NO_DIV   = 2'd2
  } path_e;

  function automatic logic pll_locked(input logic pd, input logic ar);
    return !pd && !ar;
  endfunction

  function automatic path_e pick_path(input logic pd, input logic ar,
                                      input logic zero_div);
    if (!pll_locked(pd, ar)) return PATH_UNLOCKED;
    if (zero_div) return PATH_NO_DIV;
    return PATH_DIVIDE;
  endfunction

endpackage

// File: rtl/pll_cfg_decode.sv
`timescale 1ns/1ps
module pll_cfg_decode
  import pll_eval_pkg::*;
#(
  parameter int REF_W  = 32,
  parameter int INT_W  = 10,
  parameter int FRAC_W = 20,
  parameter int DIV_W  = 3
) (
  input  logic [REF_W-1:0]                   ref_hz,
  input  logic                               pwr_down,
  input  logic                               ana_rst,
  input  logic [INT_W-1:0]                   int_mul,
  input  logic [FRAC_W-1:0]                  frac_mul,
  input  logic [DIV_W-1:0]                   post_div,
  input  logic                               pre_dbl,
  output path_e                              path,
  output logic [REF_W+INT_W+FRAC_W+2-1:0]    product
);
  localparam int MUL_W  = INT_W + FRAC_W + 2;
  localparam int PROD_W = REF_W + MUL_W;

  // Multiplier word: integer part above the binary point, fraction below.
  function automatic logic [MUL_W-1:0] build_mul(input logic [INT_W-1:0] i_part,
                                                 input logic [FRAC_W-1:0] f_part,
                                                 input logic dbl);
    logic [MUL_W-1:0] ip;
    logic [MUL_W-1:0] fp;
    ip = MUL_W'(i_part);
    fp = MUL_W'(f_part);
    if (dbl) begin
      ip = ip << 1;
      fp = fp << 1;
    end
    return (ip << FRAC_W) + fp;
  endfunction

  function automatic logic [PROD_W-1:0] scale_ref(input logic [REF_W-1:0] r,
                                                  input logic [MUL_W-1:0] m);
    return PROD_W'(r) * PROD_W'(m);
  endfunction

  logic [MUL_W-1:0] mul_word;

  always_comb begin
    mul_word = build_mul(int_mul, frac_mul, pre_dbl);
    product  = scale_ref(ref_hz, mul_word);
    path     = pick_path(pwr_down, ana_rst, post_div == '0);
  end

endmodule

// File: rtl/pll_restoring_div.sv
`timescale 1ns/1ps
module pll_restoring_div #(
  parameter int NUM_W  = 64,
  parameter int DEN_W  = 3,
  parameter int DROP_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    cancel,
  input  logic [NUM_W-1:0]        num,
  input  logic [DEN_W-1:0]        den,
  output logic                    busy,
  output logic                    fin,
  output logic [NUM_W-DROP_W-1:0] quo_hi
);
  localparam int CNT_W = $clog2(NUM_W);
  localparam int REM_W = DEN_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

  logic [NUM_W-1:0] acc;      // dividend shifts out, quotient shifts in
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt;
  logic             busy_q;

  logic [REM_W-1:0] trial;
  logic [REM_W-1:0] diff;
  logic             take;
  logic             iter_step;

  always_comb begin
    trial     = {rem, acc[NUM_W-1]};
    diff      = trial - {1'b0, den_q};
    take      = trial >= {1'b0, den_q};
    iter_step = busy_q && !load && !cancel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      rem    <= '0;
      den_q  <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        acc    <= num;
        rem    <= '0;
        den_q  <= den;
        cnt    <= '0;
        busy_q <= 1'b1;
      end else if (cancel) begin
        busy_q <= 1'b0;
      end else if (iter_step) begin
        acc <= {acc[NUM_W-2:0], take};
        rem <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        if (cnt == LAST) begin
          busy_q <= 1'b0;
          fin    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign quo_hi = acc[NUM_W-1:DROP_W];

endmodule

// File: rtl/pll_freq_eval.sv
`timescale 1ns/1ps
module pll_freq_eval
  import pll_eval_pkg::*;
#(
  parameter int REF_W  = 32,
  parameter int INT_W  = 10,
  parameter int FRAC_W = 20,
  parameter int DIV_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [REF_W-1:0]          ref_hz,
  input  logic                      pwr_down,
  input  logic                      ana_rst,
  input  logic [INT_W-1:0]          int_mul,
  input  logic [FRAC_W-1:0]         frac_mul,
  input  logic [DIV_W-1:0]          post_div,
  input  logic                      pre_dbl,
  output logic [REF_W+INT_W+2-1:0]  freq_hz,
  output logic                      done
);
  localparam int MUL_W  = INT_W + FRAC_W + 2;
  localparam int PROD_W = REF_W + MUL_W;
  localparam int OUT_W  = PROD_W - FRAC_W;

  path_e              path;
  logic [PROD_W-1:0]  product;
  logic               cfg_zero;   // start takes a forced-zero path
  logic               div_go;     // start launches a division
  logic               div_fin;
  logic               div_busy;
  logic [OUT_W-1:0]   div_quo;
  logic [OUT_W-1:0]   freq_q;
  logic               done_q;

  pll_cfg_decode #(
    .REF_W(REF_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)
  ) dec_i (
    .ref_hz   (ref_hz),
    .pwr_down (pwr_down),
    .ana_rst  (ana_rst),
    .int_mul  (int_mul),
    .frac_mul (frac_mul),
    .post_div (post_div),
    .pre_dbl  (pre_dbl),
    .path     (path),
    .product  (product)
  );

  assign cfg_zero = start && (path != PATH_DIVIDE);
  assign div_go   = start && (path == PATH_DIVIDE);

  pll_restoring_div #(
    .NUM_W(PROD_W), .DEN_W(DIV_W), .DROP_W(FRAC_W)
  ) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (div_go),
    .cancel (cfg_zero),
    .num    (product),
    .den    (post_div),
    .busy   (div_busy),
    .fin    (div_fin),
    .quo_hi (div_quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      if (cfg_zero) begin
        freq_q <= '0;
        done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end else if (div_fin) begin
      freq_q <= div_quo;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign freq_hz = freq_q;
  assign done    = done_q;

endmodule

// File: rtl/pll_freq_eval_chk.sv
`timescale 1ns/1ps
module pll_freq_eval_chk #(
  parameter int PROD_W = 64,
  parameter int OUT_W  = 44,
  parameter int DIV_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pwr_down,
  input logic             ana_rst,
  input logic [DIV_W-1:0] post_div,
  input logic             div_go,
  input logic             div_fin,
  input logic             div_busy,
  input logic [OUT_W-1:0] freq_hz,
  input logic             done
);
  localparam int LC_W = $clog2(PROD_W) + 2;
  localparam logic [LC_W-1:0] LC_MAX = '1;

  logic [LC_W-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 lat_cnt <= LC_MAX;
    else if (div_go)            lat_cnt <= '0;
    else if (lat_cnt != LC_MAX) lat_cnt <= lat_cnt + 1'b1;
  end

  p_lock_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && (pwr_down || ana_rst) |=> done && freq_hz == '0 && !div_busy);

  p_div_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && post_div == '0 |=> done && freq_hz == '0 && !div_busy);

  p_iter_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> lat_cnt == LC_W'(PROD_W));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |=> !done && div_busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_hz) |-> done);

endmodule

bind pll_freq_eval pll_freq_eval_chk #(
  .PROD_W(PROD_W), .OUT_W(OUT_W), .DIV_W(DIV_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .pwr_down (pwr_down),
  .ana_rst  (ana_rst),
  .post_div (post_div),
  .div_go   (div_go),
  .div_fin  (div_fin),
  .div_busy (div_busy),
  .freq_hz  (freq_hz),
  .done     (done)
);

// File: tb/pll_freq_eval_tb_top.sv
`timescale 1ns/1ps
module pll_freq_eval_tb_top;

  typedef struct {
    longint unsigned f;
    int              due;
    string           tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic        pwr_down = 1'b0;
  logic        ana_rst = 1'b0;
  logic [9:0]  int_mul = '0;
  logic [19:0] frac_mul = '0;
  logic [2:0]  post_div = '0;
  logic        pre_dbl = 1'b0;
  logic [43:0] freq_hz;
  logic        done;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_freq_eval dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz),
    .pwr_down(pwr_down), .ana_rst(ana_rst), .int_mul(int_mul),
    .frac_mul(frac_mul), .post_div(post_div), .pre_dbl(pre_dbl),
    .freq_hz(freq_hz), .done(done)
  );

  task automatic check(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Frequency restated as a rational value: ref * (N + F/2^20) / P, floored.
  function automatic longint unsigned model(input longint unsigned r, input bit pd,
      input bit ar, input longint unsigned n, input longint unsigned fr,
      input longint unsigned p, input bit pre);
    longint unsigned k;
    longint unsigned m;
    if (pd || ar || p == 0) return 0;
    k = pre ? 2 : 1;
    m = n * k * 1048576 + fr * k;
    return ((r * m) / p) / 1048576;
  endfunction

  task automatic kick(input longint unsigned r, input bit pd, input bit ar,
      input int n, input int fr, input int p, input bit pre,
      input string tag, input bit restart);
    exp_t e;
    @(negedge clk);
    ref_hz = r[31:0]; pwr_down = pd; ana_rst = ar; int_mul = n[9:0];
    frac_mul = fr[19:0]; post_div = p[2:0]; pre_dbl = pre; start = 1'b1;
    e.f   = model(r, pd, ar, longint'(n), longint'(fr), longint'(p), pre);
    e.due = cyc + 1 + ((pd || ar || p == 0) ? 0 : 65);
    e.tag = tag;
    if (restart && exp_q.size() > 0) void'(exp_q.pop_back());
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: every done must match the oldest expected item, value and cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(freq_hz == e.f[43:0], {e.tag, " value"}, freq_hz, e.f);
          check(cyc == e.due, {e.tag, " R6 latency"}, cyc, e.due);
        end
      end else if (exp_q.size() > 0 && cyc > exp_q[0].due) begin
        check(1'b0, {exp_q[0].tag, " R6 missing done"}, cyc, exp_q[0].due);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(freq_hz == 0 && done == 0, "R1 in reset", freq_hz, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(freq_hz == 0 && done == 0, "R1 after reset", freq_hz, 0);

    // R4 integer multiplier: 19.2 MHz * 50 / 1
    kick(19200000, 0, 0, 50, 0, 1, 0, "R4 int", 0);
    wait_idle();

    // R4 fractional multiplier, R8 hold during the next divide
    kick(19200000, 0, 0, 52, 'h80000, 2, 0, "R4 frac", 0);
    repeat (20) @(negedge clk);
    check(freq_hz == 44'd960000000, "R8 hold mid-divide", freq_hz, 960000000);
    check(done == 1'b0, "R6 done low mid-divide", done, 0);
    wait_idle();

    // R5 prescaler doubles both parts, and the same fields without it
    kick(19200000, 0, 0, 25, 'h40000, 1, 1, "R5 doubled", 0);
    wait_idle();
    kick(19200000, 0, 0, 25, 'h40000, 1, 0, "R5 plain", 0);
    wait_idle();

    // R9 truncation with an odd divider and fraction
    kick(19200000, 0, 0, 33, 12345, 7, 0, "R9 floor", 0);
    wait_idle();
    kick(1000003, 0, 0, 1, 1, 3, 1, "R9 floor small", 0);
    wait_idle();

    // R2 lock gating from a non-zero previous result
    kick(19200000, 1, 0, 50, 0, 1, 0, "R2 power-down", 0);
    wait_idle();
    kick(19200000, 0, 0, 40, 0, 5, 0, "R4 refill", 0);
    wait_idle();
    kick(19200000, 0, 1, 50, 0, 1, 0, "R2 analog-reset", 0);
    kick(19200000, 1, 1, 50, 0, 1, 0, "R2 both", 0);
    wait_idle();

    // R3 zero post-divider
    kick(19200000, 0, 0, 50, 0, 0, 0, "R3 zero div", 0);
    wait_idle();

    // R7 restart while dividing: only the second result appears
    kick(19200000, 0, 0, 50, 0, 1, 0, "R7 first", 0);
    repeat (10) @(negedge clk);
    kick(19200000, 0, 0, 61, 'h12345, 3, 1, "R7 restart", 1);
    wait_idle();
    repeat (80) @(negedge clk);

    // R7 restart into a forced-zero path
    kick(19200000, 0, 0, 70, 0, 1, 0, "R7 first b", 0);
    repeat (30) @(negedge clk);
    kick(19200000, 0, 0, 70, 0, 0, 0, "R7 zero restart", 1);
    wait_idle();
    repeat (80) @(negedge clk);
    check(freq_hz == 0, "R7 no late result", freq_hz, 0);

    // R10 widest inputs
    kick(64'hFFFFFFFF, 0, 0, 1023, 'hFFFFF, 1, 1, "R10 full range", 0);
    wait_idle();
    kick(64'hFFFFFFFF, 0, 0, 1023, 'hFFFFF, 7, 1, "R10 full range div7", 0);
    wait_idle();

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule